// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Core

This block is the clocked front end and storage array of a pipelined burst SRAM. The word is split into byte lanes, and each lane holds eight data bits and one parity bit. At every rising clock edge the core samples two competing address strobes, three chip enables, an advance input and the write controls. It then starts a new access, continues or suspends the running burst, or deselects. A 2-bit burst counter walks the low address bits in linear or interleaved order. The order is chosen by a static strap.

Read data leaves through an output register one edge after the access is registered. An asynchronous, active-low output enable gates the drive flag. The drive flag stays low during the first clock of an access that starts from the deselected state. The bidirectional data pins of a packaged part appear here as a data input bus, a data output bus and a drive-enable flag. All pins are plain, level-sampled controls with no handshake: every edge is an accepted command, and the core never applies back-pressure.

The full-size configuration uses a 17-bit address (`ADDR_W = 17`). The default parameter keeps the array small so that the design elaborates quickly.

Top module: `sbs_core`

## Requirements
- R1: An access starts at an edge only when a recognised strobe is low and all three enables are active: `ce1_n`=0, `ce2`=1, `ce3_n`=0. A recognised strobe with any enable inactive deselects the core, and no access or write happens.
- R2: When both strobes are low and `ce1_n`=0, the processor strobe wins. An access started by the processor strobe is always a read, even when the write controls are active.
- R3: The processor strobe is ignored while `ce1_n`=1. With the controller strobe high, such a cycle continues the running burst.
- R4: With `order_il`=0, the burst offsets are start, start+1, start+2, start+3, taken modulo 4 in the low two address bits. The upper address bits stay fixed.
- R5: With `order_il`=1, the burst address low bits are the start bits XOR the counter values 0, 1, 2, 3 in turn. The upper address bits stay fixed.
- R6: In a running burst with no strobe recognised, `step_n`=0 advances the counter before that cycle's access. `step_n`=1 repeats the current address.
- R7: `wr_all_n`=0 writes all lanes, whatever the values of `wr_byte_n` and `lane_sel_n`.
- R8: With `wr_all_n`=1, a write occurs only when `wr_byte_n`=0, and then only to the lanes whose `lane_sel_n` bit is 0. Lane i holds data bits [8i+7:8i] and parity bit 32+i.
- R9: Read data appears on `dout` after the edge that follows the edge at which the read access was registered.
- R10: `dout_en` equals NOT `oe_n` combinationally whenever the core owns the bus, and 0 otherwise. It is forced to 0 during the clock after an access that starts from the deselected state.
- R11: After a deselecting edge, the data of the last read is still driven for one clock and then released.
- R12: During and right after reset, `dout_en` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cpu_strb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write qualifier, active low |
| lane_sel_n | input | LANES | Lane selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| din | input | LANES*9 | Write data, parity bits in the top LANES bits |
| dout | output | LANES*9 | Registered read data |
| dout_en | output | 1 | Drive flag for the data pins |

## Verification
Two behaviours are hardest to reach from the ports. The first is a processor strobe that arrives during a running burst while `ce1_n` is high; it must be seen as a plain continuation and not as a deselect. The stimulus raises `ce1_n` and pulls the processor strobe low in the middle of a burst. It then checks that the next beat returns the following burst address while `dout_en` stays high. The second is the mask on an access that starts from the deselected state. The stimulus always deselects before each table burst, holds `oe_n` low, and checks that `dout_en` is low during the first clock and high on the next.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    CMD_IDLE     = 2'd0,
    CMD_START    = 2'd1,
    CMD_CONTINUE = 2'd2,
    CMD_DESELECT = 2'd3
  } seq_cmd_e;

endpackage

// File: rtl/sbs_seq.sv
module sbs_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              order_il,
  output logic              acc_go,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              cpu_start,
  output logic              from_idle,
  output logic              active_q
);

  localparam int UPPER_W = ADDR_W - BURST_W;

  logic              sel_all;
  logic              cpu_hit;
  logic              ctl_hit;
  logic              strobe;
  seq_cmd_e          cmd;
  burst_order_e      order;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] off_q;
  logic [BURST_W-1:0] off_nx;
  logic [BURST_W-1:0] low_nx;

  assign sel_all = ~ce1_n & ce2 & ~ce3_n;
  // processor strobe only counts while the first enable is low
  assign cpu_hit = ~cpu_strb_n & ~ce1_n;
  assign ctl_hit = ~ctl_strb_n & ~cpu_hit;
  assign strobe  = cpu_hit | ctl_hit;
  assign order   = burst_order_e'(order_il);

  always_comb begin
    if (strobe)        cmd = sel_all ? CMD_START : CMD_DESELECT;
    else if (active_q) cmd = CMD_CONTINUE;
    else               cmd = CMD_IDLE;
  end

  always_comb begin
    off_nx = off_q;
    if (cmd == CMD_CONTINUE && !step_n) off_nx = off_q + 1'b1;
  end

  always_comb begin
    if (order == ORDER_XOR) low_nx = base_q[BURST_W-1:0] ^ off_nx;
    else                    low_nx = base_q[BURST_W-1:0] + off_nx;
  end

  assign acc_go    = (cmd == CMD_START) | (cmd == CMD_CONTINUE);
  assign acc_addr  = (cmd == CMD_START) ? addr : {base_q[ADDR_W-1 -: UPPER_W], low_nx};
  assign cpu_start = (cmd == CMD_START) & cpu_hit;
  assign from_idle = (cmd == CMD_START) & ~active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      off_q    <= '0;
    end else begin
      case (cmd)
        CMD_START: begin
          active_q <= 1'b1;
          base_q   <= addr;
          off_q    <= '0;
        end
        CMD_DESELECT: active_q <= 1'b0;
        CMD_CONTINUE: off_q <= off_nx;
        default: ;
      endcase
    end
  end

  // R1: a burst only becomes active after a strobe with all enables active
  a_r1_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(~ce1_n & ce2 & ~ce3_n & (~cpu_strb_n | ~ctl_strb_n)));

  // R4 / R6: a continuation with advance low steps the counter by one
  a_r4_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cpu_strb_n && ctl_strb_n && !step_n) |=> off_q == $past(off_q) + 1'b1);

  // R6: a continuation with advance high holds the burst position
  a_r6_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cpu_strb_n && ctl_strb_n && step_n) |=> ($stable(off_q) && $stable(base_q)));

  // R3: processor strobe with first enable high never ends a burst on its own
  a_r3_cpu_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && ce1_n && !cpu_strb_n && ctl_strb_n) |=> active_q);

endmodule

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_go,
  input  logic             cpu_start,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_go
);

  logic [LANES-1:0] lanes_req;
  logic             wr_go;

  always_comb begin
    if (!wr_all_n)       lanes_req = '1;
    else if (!wr_byte_n) lanes_req = ~lane_sel_n;
    else                 lanes_req = '0;
  end

  // an access opened by the processor strobe is a read
  assign wr_go   = acc_go & ~cpu_start & (|lanes_req);
  assign lane_we = wr_go ? lanes_req : '0;
  assign rd_go   = acc_go & ~wr_go;

  // R2: the processor-strobe start cycle writes nothing
  a_r2_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |-> (lane_we == '0 && rd_go));

  // R7: global write covers every lane on a write access
  a_r7_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !cpu_start && !wr_all_n) |-> (&lane_we));

  // R8: no lane is written without some write qualifier
  a_r8_needs_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_n && wr_byte_n) |-> (lane_we == '0));

endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int ADDR_W    = 10,
  parameter int LANES     = 4,
  parameter int LANE_DATA = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            acc_addr,
  input  logic [LANES-1:0]             lane_we,
  input  logic                         rd_go,
  input  logic [LANES*(LANE_DATA+1)-1:0] din,
  output logic [LANES*(LANE_DATA+1)-1:0] rd_word,
  output logic                         live_q
);

  localparam int LANE_W    = LANE_DATA + 1;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int DATA_BITS = LANES * LANE_DATA;

  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_pend_q <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      rd_addr_q <= acc_addr;
      rd_pend_q <= rd_go;
      live_q    <= rd_pend_q;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[acc_addr] <= {din[DATA_BITS+g], din[g*LANE_DATA +: LANE_DATA]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (rd_pend_q) q <= mem[rd_addr_q];
    end

    assign rd_word[g*LANE_DATA +: LANE_DATA] = q[LANE_DATA-1:0];
    assign rd_word[DATA_BITS+g]              = q[LANE_DATA];
  end

  // R9: a read access is followed by live data one edge later
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> ##1 live_q);

endmodule

// File: rtl/sbs_drive.sv
module sbs_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic active_q,
  input  logic live_q,
  input  logic from_idle,
  output logic dout_en
);

  logic fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= 1'b0;
    else        fresh_q <= from_idle;
  end

  assign dout_en = ~oe_n & (active_q | live_q) & ~fresh_q;

  // R10: first clock after a start from deselect is never driven
  a_r10_fresh_masked: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q |-> !dout_en);

  // R11: with no burst and no live data the pins are released
  a_r11_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !live_q) |-> !dout_en);

endmodule

// File: rtl/sbs_core.sv
module sbs_core #(
  parameter int ADDR_W    = 10,
  parameter int LANES     = 4,
  parameter int LANE_DATA = 8,
  parameter int BURST_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           cpu_strb_n,
  input  logic                           ctl_strb_n,
  input  logic                           step_n,
  input  logic                           ce1_n,
  input  logic                           ce2,
  input  logic                           ce3_n,
  input  logic                           wr_all_n,
  input  logic                           wr_byte_n,
  input  logic [LANES-1:0]               lane_sel_n,
  input  logic                           oe_n,
  input  logic                           order_il,
  input  logic [LANES*(LANE_DATA+1)-1:0] din,
  output logic [LANES*(LANE_DATA+1)-1:0] dout,
  output logic                           dout_en
);

  logic              acc_go;
  logic [ADDR_W-1:0] acc_addr;
  logic              cpu_start;
  logic              from_idle;
  logic              active_q;
  logic [LANES-1:0]  lane_we;
  logic              rd_go;
  logic              live_q;

  sbs_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .order_il(order_il),
    .acc_go(acc_go), .acc_addr(acc_addr), .cpu_start(cpu_start),
    .from_idle(from_idle), .active_q(active_q)
  );

  sbs_lane_dec #(.LANES(LANES)) u_dec (
    .clk(clk), .rst_n(rst_n), .acc_go(acc_go), .cpu_start(cpu_start),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .lane_we(lane_we), .rd_go(rd_go)
  );

  sbs_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_DATA(LANE_DATA)) u_store (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .lane_we(lane_we),
    .rd_go(rd_go), .din(din), .rd_word(dout), .live_q(live_q)
  );

  sbs_drive u_drive (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .active_q(active_q),
    .live_q(live_q), .from_idle(from_idle), .dout_en(dout_en)
  );

  // R12: nothing is driven while reset is held
  a_r12_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !dout_en);

endmodule

// File: tb/sim_sbs_core.sv
module sim_sbs_core;

  localparam int AW = 10;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, step_n = 1'b1;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0]    lane_sel_n = 4'hF;
  logic          oe_n = 1'b0, order_il = 1'b0;
  logic [WW-1:0] din = '0;
  logic [WW-1:0] dout;
  logic          dout_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [WW-1:0] ref_mem [64];

  // mode, use_cpu, base[9:0], four 2-bit expected offsets (first beat in the top bits)
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 1'b0, 10'h010, 8'h1B},
    {1'b0, 1'b1, 10'h015, 8'h6C},
    {1'b0, 1'b0, 10'h01A, 8'hB1},
    {1'b0, 1'b1, 10'h027, 8'hC6},
    {1'b1, 1'b0, 10'h030, 8'h1B},
    {1'b1, 1'b1, 10'h031, 8'h4E},
    {1'b1, 1'b0, 10'h036, 8'hB1},
    {1'b1, 1'b1, 10'h03B, 8'hE4}
  };

  sbs_core u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n), .step_n(step_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .oe_n(oe_n), .order_il(order_il), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
    return {a[3:0] ^ 4'h9, a[7:0] ^ 8'h5A, ~a[7:0], a[7:0] + 8'h33, {a[9:8], a[5:0]}};
  endfunction

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; step_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF;
  endtask

  task automatic deselect();
    idle();
    ctl_strb_n = 1'b0; ce2 = 1'b0;
    tick();
    idle();
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic all_n, input logic byte_n,
                     input logic [3:0] sel_n, input logic [WW-1:0] d);
    idle();
    addr = a; ctl_strb_n = 1'b0; wr_all_n = all_n; wr_byte_n = byte_n;
    lane_sel_n = sel_n; din = d;
    tick();
    deselect();
  endtask

  task automatic rd1(input logic [AW-1:0] a, output logic [WW-1:0] d);
    idle();
    addr = a; ctl_strb_n = 1'b0;
    tick();
    deselect();
    d = dout;
    tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] got;
    logic [WW-1:0] mask;
    logic [WW-1:0] d;
    idle();
    oe_n = 1'b0;
    repeat (3) tick();
    // R12: reset keeps the pins released
    chk("R12 en in reset", {35'd0, dout_en}, 36'd0);
    rst_n = 1'b1;
    tick();
    chk("R12 en after reset", {35'd0, dout_en}, 36'd0);

    // fill addresses 0..63 with linear write bursts
    order_il = 1'b0;
    for (int b = 0; b < 16; b++) begin
      idle();
      addr = AW'(b * 4); ctl_strb_n = 1'b0; wr_all_n = 1'b0; din = pat(AW'(b * 4));
      tick();
      for (int k = 1; k < 4; k++) begin
        idle();
        step_n = 1'b0; wr_all_n = 1'b0; din = pat(AW'(b * 4 + k));
        tick();
      end
      deselect();
    end
    for (int i = 0; i < 64; i++) ref_mem[i] = pat(AW'(i));

    // table walk: R4/R5 order, R9 latency, R10 mask, R11 release
    for (int v = 0; v < 8; v++) begin
      logic [AW-1:0] base;
      logic [7:0]    seq;
      logic [5:0]    ea;
      string         otag;
      base = VEC[v][17:8];
      seq  = VEC[v][7:0];
      otag = VEC[v][19] ? "R5" : "R4";
      idle();
      order_il = VEC[v][19];
      tick();
      addr = base;
      if (VEC[v][18]) cpu_strb_n = 1'b0; else ctl_strb_n = 1'b0;
      tick();
      chk("R10 first clock masked", {35'd0, dout_en}, 36'd0);
      for (int k = 0; k < 3; k++) begin
        idle();
        step_n = 1'b0;
        tick();
        ea = {base[5:2], seq[7 - 2*k -: 2]};
        chk({otag, " R9 beat data"}, dout, ref_mem[ea]);
        chk("R10 driven", {35'd0, dout_en}, 36'd1);
      end
      deselect();
      ea = {base[5:2], seq[1:0]};
      chk({otag, " last beat"}, dout, ref_mem[ea]);
      chk("R11 driven after deselect", {35'd0, dout_en}, 36'd1);
      tick();
      chk("R11 released", {35'd0, dout_en}, 36'd0);
    end
    order_il = 1'b0;
    tick();

    // R1: strobes with an inactive enable write nothing
    idle(); addr = 10'd5; ctl_strb_n = 1'b0; ce3_n = 1'b1; wr_all_n = 1'b0; din = ~pat(10'd5);
    tick(); idle(); tick();
    rd1(10'd5, got);
    chk("R1 ce3 inactive", got, ref_mem[5]);
    idle(); addr = 10'd6; ctl_strb_n = 1'b0; ce2 = 1'b0; wr_all_n = 1'b0; din = ~pat(10'd6);
    tick(); idle(); tick();
    rd1(10'd6, got);
    chk("R1 ce2 inactive", got, ref_mem[6]);

    // R2: both strobes low -> processor start, a read, no write
    idle(); addr = 10'd7; cpu_strb_n = 1'b0; ctl_strb_n = 1'b0; wr_all_n = 1'b0; din = ~pat(10'd7);
    tick();
    deselect();
    rd1(10'd7, got);
    chk("R2 processor start does not write", got, ref_mem[7]);

    // R7: global write ignores lane controls
    d = 36'h1_2345_6789;
    wr1(10'd8, 1'b0, 1'b1, 4'hF, d);
    ref_mem[8] = d;
    rd1(10'd8, got);
    chk("R7 global write", got, ref_mem[8]);

    // R8: lanes 0 and 2 only
    d = 36'hF_FFFF_FFFF;
    wr1(10'd9, 1'b1, 1'b0, 4'b1010, d);
    mask = 36'h5_00FF_00FF;
    ref_mem[9] = (ref_mem[9] & ~mask) | (d & mask);
    rd1(10'd9, got);
    chk("R8 lane write", got, ref_mem[9]);
    // R8: lane selects without the qualifier do nothing
    wr1(10'd10, 1'b1, 1'b1, 4'h0, 36'd0);
    rd1(10'd10, got);
    chk("R8 no qualifier", got, ref_mem[10]);

    // R6 hold and R3 ignored processor strobe mid-burst
    idle(); addr = 10'h014; ctl_strb_n = 1'b0;
    tick();
    idle(); step_n = 1'b1;
    tick();
    chk("R6 first beat", dout, ref_mem[20]);
    idle(); step_n = 1'b0; cpu_strb_n = 1'b0; ce1_n = 1'b1;
    tick();
    chk("R6 held beat", dout, ref_mem[20]);
    idle(); step_n = 1'b0;
    tick();
    chk("R3 burst continues", dout, ref_mem[21]);
    chk("R3 still driven", {35'd0, dout_en}, 36'd1);
    deselect();
    chk("R6 next beat", dout, ref_mem[22]);
    tick();

    // R10: output enable acts without a clock
    idle(); addr = 10'h020; ctl_strb_n = 1'b0;
    tick();
    idle(); step_n = 1'b0;
    tick();
    chk("R10 en low oe", {35'd0, dout_en}, 36'd1);
    oe_n = 1'b1; #1;
    chk("R10 oe high releases", {35'd0, dout_en}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R10 oe low drives", {35'd0, dout_en}, 36'd1);
    deselect();
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule